// File: doc/BRIEF.md
# Banked Instruction-Fault Virtual Address Register

This block holds the virtual address of the most recent faulting instruction fetch. It keeps two storage entries, one for the Secure world and one for the Non-secure world. Software reaches it through a coprocessor-style system register port. Each request carries a five-field encoding (coprocessor number, opc1, CRn, CRm, opc2), a read/write flag and write data. The core also supplies its privilege level and the hypervisor and monitor configuration. When the core reports a prefetch abort, the block records the faulting address in the entry of the current security state.

For each request whose encoding selects this register, a decoder classifies the access. The result is an undefined-instruction response, a trap to the hypervisor level carrying code 0x03 and a flag giving the trap kind, or a read or write of one entry. A response sequencer returns one registered response per request. It is a two-state machine. ST_IDLE has no response pending and ST_ACK presents a response. Its transitions are ACCEPT (ST_IDLE to ST_ACK on a selected request), CHAIN (ST_ACK to ST_ACK on a back-to-back request) and RELEASE (ST_ACK to ST_IDLE when no request follows). An encoding that does not select this register gets no response and changes nothing.

The storage entries have no reset, so their contents are undefined until the first write or capture.

Top module: `fetch_fault_va_reg`

## Requirements
- R1: A request is handled only when cp=15, opc1=0, CRn=6, CRm=0 and opc2=2. Any other encoding gives no response (rsp_valid stays 0) and leaves both entries unchanged.
- R2: A handled request sampled at a clock edge yields rsp_valid=1 for the cycle after that edge, so there is one response per request. rsp_valid is 0 during and after reset until a request arrives. The rsp_kind encoding is 0=read OK with data, 1=write OK, 2=undefined, 3=trap. Read data is the entry's value before that edge.
- R3: cur_el is coded 0 to 3 for EL0 to EL3. Any access at EL0 returns undefined.
- R4: At EL1, with hyp_en=1 and trap_grp6=1, every access returns trap with rsp_code=0x03. This check wins over both virtual-memory trap bits.
- R5: At EL1 with hyp_en=1, a read traps (code 0x03) when trap_vm_rd=1, and a write traps when trap_vm_wr=1. Each bit affects only its own direction. With hyp_en=0, no trap bit has any effect.
- R6: For a trap, rsp_trap64 equals hyp_is64: 1 means a 64-bit-style system access trap, 0 means a 32-bit hypervisor trap exception. It is 0 for every other result.
- R7: At EL1 and EL2, accesses that do not trap use the Non-secure entry. This is the banked Non-secure copy when mon_present=1 and mon_is32=1, and otherwise the single shared copy, which is held in the Non-secure entry. EL2 accesses never trap.
- R8: At EL3, sec_ns=0 selects the Secure entry and sec_ns=1 selects the Non-secure entry.
- R9: An access that returns undefined or trap leaves both entries unchanged.
- R10: When abort_valid=1, abort_va is written to the Secure entry if cur_el=3 and sec_ns=0, and to the Non-secure entry otherwise.
- R11: When a capture and a software write target the same entry in the same cycle, the capture value is stored. The write still returns write OK.
- R12: With parameter PRESENT=0, every handled request returns undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opc2 field |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| sec_ns | input | 1 | Security-state bit used at EL3 |
| hyp_en | input | 1 | Hypervisor level enabled |
| hyp_is64 | input | 1 | Hypervisor level uses 64-bit state |
| mon_present | input | 1 | Monitor level implemented |
| mon_is32 | input | 1 | Monitor level uses 32-bit state |
| trap_grp6 | input | 1 | Hypervisor trap for register group 6 |
| trap_vm_rd | input | 1 | Hypervisor virtual-memory read trap |
| trap_vm_wr | input | 1 | Hypervisor virtual-memory write trap |
| abort_valid | input | 1 | Prefetch-abort capture strobe |
| abort_va | input | 32 | Faulting fetch virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | Result: 0 read, 1 write, 2 undefined, 3 trap |
| rsp_rdata | output | 32 | Read data (0 unless read OK) |
| rsp_code | output | 6 | Trap code (0x03 on trap, else 0) |
| rsp_trap64 | output | 1 | Trap kind flag |

## Verification
A vector table sweeps privilege level against the trap controls. Every trap bit is tried alone and together with the others, so group-trap priority, read/write trap separation and the gating by hyp_en can each be told apart. Secure and Non-secure writes are interleaved with reads from each level, which shows which entry each level reaches and whether a refused access disturbed any contents. Directed tests cover each single-field encoding mismatch, captures in both security states, a capture colliding with a write to the same entry, and an instance built with PRESENT=0.

// File: rtl/ffv_pkg.sv
package ffv_pkg;
    localparam int unsigned NBANK    = 2;
    localparam int unsigned BANK_NS  = 0;
    localparam int unsigned BANK_SEC = 1;

    typedef enum logic [1:0] {
        RES_RD    = 2'd0,
        RES_WR    = 2'd1,
        RES_UNDEF = 2'd2,
        RES_TRAP  = 2'd3
    } res_e;

    typedef struct packed {
        res_e res;
        logic use_sec;
        logic trap64;
    } verdict_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/ffv_decode.sv
module ffv_decode
    import ffv_pkg::*;
#(
    parameter bit         PRESENT = 1'b1,
    parameter logic [3:0] SEL_CP  = 4'd15,
    parameter logic [2:0] SEL_OP1 = 3'd0,
    parameter logic [3:0] SEL_CRN = 4'd6,
    parameter logic [3:0] SEL_CRM = 4'd0,
    parameter logic [2:0] SEL_OP2 = 3'd2
) (
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [3:0] req_cp,
    input  logic [2:0] req_op1,
    input  logic [3:0] req_crn,
    input  logic [3:0] req_crm,
    input  logic [2:0] req_op2,
    input  logic [1:0] cur_el,
    input  logic       sec_ns,
    input  logic       hyp_en,
    input  logic       hyp_is64,
    input  logic       trap_grp6,
    input  logic       trap_vm_rd,
    input  logic       trap_vm_wr,
    output logic       acc_hit,
    output verdict_t   verdict
);
    logic vm_trap;

    assign acc_hit = req_valid && (req_cp == SEL_CP) && (req_op1 == SEL_OP1)
                  && (req_crn == SEL_CRN) && (req_crm == SEL_CRM)
                  && (req_op2 == SEL_OP2);

    // Direction-specific virtual-memory trap control
    assign vm_trap = req_write ? trap_vm_wr : trap_vm_rd;

    always_comb begin
        verdict.res     = RES_UNDEF;
        verdict.use_sec = 1'b0;
        verdict.trap64  = 1'b0;
        if (PRESENT) begin
            unique case (cur_el)
                2'd0: verdict.res = RES_UNDEF;
                2'd1: begin
                    if (hyp_en && trap_grp6) begin
                        verdict.res    = RES_TRAP;
                        verdict.trap64 = hyp_is64;
                    end else if (hyp_en && vm_trap) begin
                        verdict.res    = RES_TRAP;
                        verdict.trap64 = hyp_is64;
                    end else begin
                        verdict.res = req_write ? RES_WR : RES_RD;
                    end
                end
                2'd2: verdict.res = req_write ? RES_WR : RES_RD;
                2'd3: begin
                    verdict.res     = req_write ? RES_WR : RES_RD;
                    verdict.use_sec = !sec_ns;
                end
                default: verdict.res = RES_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/ffv_store.sv
module ffv_store
    import ffv_pkg::*;
#(
    parameter int unsigned VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sec,
    input  logic [VA_W-1:0] wr_data,
    input  logic            cap_en,
    input  logic            cap_sec,
    input  logic [VA_W-1:0] cap_data,
    output logic [VA_W-1:0] sec_q,
    output logic [VA_W-1:0] nsec_q
);
    logic [VA_W-1:0] bank_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic SEL = (b == BANK_SEC);
        // Entries carry no reset: contents undefined until first update
        always_ff @(posedge clk) begin
            if (cap_en && (cap_sec == SEL)) begin
                bank_q[b] <= cap_data;
            end else if (wr_en && (wr_sec == SEL)) begin
                bank_q[b] <= wr_data;
            end
        end
    end

    assign sec_q  = bank_q[BANK_SEC];
    assign nsec_q = bank_q[BANK_NS];

    // R10: a capture lands in the entry it names
    a_r10_capture_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (($past(cap_sec) ? sec_q : nsec_q) === $past(cap_data)));

    // R11: capture beats a colliding software write
    a_r11_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && wr_en && (cap_sec == wr_sec) && (cap_data != wr_data))
        |=> (($past(cap_sec) ? sec_q : nsec_q) !== $past(wr_data)));
endmodule

// File: rtl/ffv_rsp_fsm.sv
module ffv_rsp_fsm
    import ffv_pkg::*;
#(
    parameter int unsigned        VA_W      = 32,
    parameter int unsigned        CODE_W    = 6,
    parameter logic [CODE_W-1:0]  TRAP_CODE = 6'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_hit,
    input  verdict_t          verdict,
    input  logic [VA_W-1:0]   sec_q,
    input  logic [VA_W-1:0]   nsec_q,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [VA_W-1:0]   rsp_rdata,
    output logic [CODE_W-1:0] rsp_code,
    output logic              rsp_trap64
);
    rsp_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, CHAIN, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_hit ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = acc_hit ? ST_ACK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output register, loaded on each accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_kind   <= RES_UNDEF;
            rsp_rdata  <= '0;
            rsp_code   <= '0;
            rsp_trap64 <= 1'b0;
        end else if (acc_hit) begin
            rsp_kind   <= verdict.res;
            rsp_rdata  <= (verdict.res == RES_RD)
                        ? (verdict.use_sec ? sec_q : nsec_q) : '0;
            rsp_code   <= (verdict.res == RES_TRAP) ? TRAP_CODE : '0;
            rsp_trap64 <= (verdict.res == RES_TRAP) && verdict.trap64;
        end
    end

    assign rsp_valid = (state_q == ST_ACK);

    // R2: every response pulse is preceded by an accepted request
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_hit));

    // R6: trap flag only accompanies a trap result
    a_r6_flag_only_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap64) |-> (rsp_kind == RES_TRAP));
endmodule

// File: rtl/fetch_fault_va_reg.sv
module fetch_fault_va_reg
    import ffv_pkg::*;
#(
    parameter bit                 PRESENT   = 1'b1,
    parameter int unsigned        VA_W      = 32,
    parameter int unsigned        CODE_W    = 6,
    parameter logic [CODE_W-1:0]  TRAP_CODE = 6'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_cp,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [VA_W-1:0]   req_wdata,
    input  logic [1:0]        cur_el,
    input  logic              sec_ns,
    input  logic              hyp_en,
    input  logic              hyp_is64,
    input  logic              mon_present,
    input  logic              mon_is32,
    input  logic              trap_grp6,
    input  logic              trap_vm_rd,
    input  logic              trap_vm_wr,
    input  logic              abort_valid,
    input  logic [VA_W-1:0]   abort_va,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [VA_W-1:0]   rsp_rdata,
    output logic [CODE_W-1:0] rsp_code,
    output logic              rsp_trap64
);
    logic            acc_hit;
    verdict_t        verdict;
    logic [VA_W-1:0] sec_q, nsec_q;
    logic            wr_en, cap_sec, banked_cfg;

    // Banked and shared configurations both resolve EL1/EL2 to the NS entry
    assign banked_cfg = mon_present && mon_is32;
    assign wr_en      = acc_hit && (verdict.res == RES_WR);
    assign cap_sec    = (cur_el == 2'd3) && !sec_ns;

    ffv_decode #(.PRESENT(PRESENT)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cp    (req_cp),
        .req_op1   (req_op1),
        .req_crn   (req_crn),
        .req_crm   (req_crm),
        .req_op2   (req_op2),
        .cur_el    (cur_el),
        .sec_ns    (sec_ns),
        .hyp_en    (hyp_en),
        .hyp_is64  (hyp_is64),
        .trap_grp6 (trap_grp6),
        .trap_vm_rd(trap_vm_rd),
        .trap_vm_wr(trap_vm_wr),
        .acc_hit   (acc_hit),
        .verdict   (verdict)
    );

    ffv_store #(.VA_W(VA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sec  (verdict.use_sec),
        .wr_data (req_wdata),
        .cap_en  (abort_valid),
        .cap_sec (cap_sec),
        .cap_data(abort_va),
        .sec_q   (sec_q),
        .nsec_q  (nsec_q)
    );

    ffv_rsp_fsm #(.VA_W(VA_W), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_hit   (acc_hit),
        .verdict   (verdict),
        .sec_q     (sec_q),
        .nsec_q    (nsec_q),
        .rsp_valid (rsp_valid),
        .rsp_kind  (rsp_kind),
        .rsp_rdata (rsp_rdata),
        .rsp_code  (rsp_code),
        .rsp_trap64(rsp_trap64)
    );

    // R1: an unselected encoding produces no response
    a_r1_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |=> !rsp_valid);

    // R3: EL0 is always refused
    a_r3_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && (cur_el == 2'd0)) |=> (rsp_valid && (rsp_kind == RES_UNDEF)));

    // R4 / R6: group trap at EL1 with kind from hypervisor width
    a_r4_group_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && PRESENT && (cur_el == 2'd1) && hyp_en && trap_grp6)
        |=> ((rsp_kind == RES_TRAP) && (rsp_code == TRAP_CODE)
             && (rsp_trap64 == $past(hyp_is64))));

    // R7: EL2 never traps
    a_r7_el2_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && PRESENT && (cur_el == 2'd2)) |=> (rsp_kind != RES_TRAP));

    // R9: a refused access disturbs neither entry
    a_r9_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && !abort_valid
         && ((verdict.res == RES_UNDEF) || (verdict.res == RES_TRAP)))
        |=> ((sec_q === $past(sec_q)) && (nsec_q === $past(nsec_q))));

    // R12: absent register refuses everything
    a_r12_absent_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && !PRESENT) |=> (rsp_kind == RES_UNDEF));

    // Configuration bit is informational to the bank choice (R7)
    a_r7_cfg_known: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && (cur_el == 2'd1) && !banked_cfg) |-> !verdict.use_sec);
endmodule

// File: tb/fetch_fault_va_reg_tb.sv
module fetch_fault_va_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [3:0]  req_cp = 4'd15, req_crn = 4'd6, req_crm = 4'd0;
    logic [2:0]  req_op1 = 3'd0, req_op2 = 3'd2;
    logic [31:0] req_wdata = 0;
    logic [1:0]  cur_el = 0;
    logic        sec_ns = 1, hyp_en = 0, hyp_is64 = 0, mon_present = 1, mon_is32 = 1;
    logic        trap_grp6 = 0, trap_vm_rd = 0, trap_vm_wr = 0;
    logic        abort_valid = 0;
    logic [31:0] abort_va = 0;
    logic        rsp_valid, rsp_trap64, a_valid, a_trap64;
    logic [1:0]  rsp_kind, a_kind;
    logic [31:0] rsp_rdata, a_rdata;
    logic [5:0]  rsp_code, a_code;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_fault_va_reg u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cp(req_cp), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el), .sec_ns(sec_ns),
        .hyp_en(hyp_en), .hyp_is64(hyp_is64), .mon_present(mon_present),
        .mon_is32(mon_is32), .trap_grp6(trap_grp6), .trap_vm_rd(trap_vm_rd),
        .trap_vm_wr(trap_vm_wr), .abort_valid(abort_valid), .abort_va(abort_va),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .rsp_code(rsp_code), .rsp_trap64(rsp_trap64));

    fetch_fault_va_reg #(.PRESENT(1'b0)) u_absent (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cp(req_cp), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el), .sec_ns(sec_ns),
        .hyp_en(hyp_en), .hyp_is64(hyp_is64), .mon_present(mon_present),
        .mon_is32(mon_is32), .trap_grp6(trap_grp6), .trap_vm_rd(trap_vm_rd),
        .trap_vm_wr(trap_vm_wr), .abort_valid(abort_valid), .abort_va(abort_va),
        .rsp_valid(a_valid), .rsp_kind(a_kind), .rsp_rdata(a_rdata),
        .rsp_code(a_code), .rsp_trap64(a_trap64));

    typedef struct packed {
        logic [1:0]  el;
        logic        wr, ns, hen, h64, m32, t6, vrd, vwr;
        logic [31:0] data;
        logic [1:0]  kind;
        logic        t64;
    } vec_t;

    // kind: 0 read, 1 write, 2 undefined, 3 trap
    localparam vec_t VECS [NV] = '{
        '{2'd3,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hA1A1_0001,2'd1,1'b0},
        '{2'd3,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hB2B2_0002,2'd1,1'b0},
        '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hA1A1_0001,2'd0,1'b0},
        '{2'd3,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hB2B2_0002,2'd0,1'b0},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hB2B2_0002,2'd0,1'b0},
        '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hC3C3_0003,2'd1,1'b0},
        '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hA1A1_0001,2'd0,1'b0},
        '{2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0000_0000,2'd2,1'b0},
        '{2'd0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hD4D4_0004,2'd2,1'b0},
        '{2'd3,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hC3C3_0003,2'd0,1'b0},
        '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,32'h1111_1111,2'd3,1'b1},
        '{2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0000_0000,2'd3,1'b0},
        '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,32'h0000_0000,2'd3,1'b1},
        '{2'd1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,32'hE5E5_0005,2'd1,1'b0},
        '{2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,32'hE5E5_0005,2'd0,1'b0},
        '{2'd1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,32'hF6F6_0006,2'd3,1'b0},
        '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hE5E5_0005,2'd0,1'b0},
        '{2'd1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,32'h1717_0017,2'd1,1'b0},
        '{2'd2,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,32'h1717_0017,2'd0,1'b0},
        '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'hA1A1_0001,2'd0,1'b0},
        '{2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h9999_0099,2'd1,1'b0},
        '{2'd3,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h9999_0099,2'd0,1'b0}
    };

    localparam string VTAG [NV] = '{
        "R8", "R8", "R8", "R8", "R7", "R7", "R9", "R3", "R3", "R9", "R4",
        "R4", "R5", "R5", "R5", "R5", "R9", "R5", "R7", "R8", "R7", "R7"
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_req(input logic [1:0] el, input logic wr, input logic ns,
                           input logic hen, input logic h64, input logic m32,
                           input logic t6, input logic vrd, input logic vwr,
                           input logic [31:0] d);
        req_valid = 1; req_write = wr; cur_el = el; sec_ns = ns;
        hyp_en = hen; hyp_is64 = h64; mon_present = 1; mon_is32 = m32;
        trap_grp6 = t6; trap_vm_rd = vrd; trap_vm_wr = vwr; req_wdata = d;
    endtask

    task automatic read_back(input logic [1:0] el, input logic ns,
                             input string tag, input logic [31:0] exp);
        set_req(el, 1'b0, ns, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        step();
        req_valid = 0;
        check(tag, {31'd0, rsp_valid}, 32'd1);
        check(tag, {30'd0, rsp_kind}, 32'd0);
        check(tag, rsp_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R2: no response during and just after reset
        #(CLK_PERIOD * 2 + 1);
        check("R2 reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1;
        step();
        check("R2 idle", {31'd0, rsp_valid}, 32'd0);

        // Table walk, back-to-back requests
        for (int i = 0; i < NV; i++) begin
            set_req(VECS[i].el, VECS[i].wr, VECS[i].ns, VECS[i].hen, VECS[i].h64,
                    VECS[i].m32, VECS[i].t6, VECS[i].vrd, VECS[i].vwr, VECS[i].data);
            step();
            check({VTAG[i], " R2 valid"}, {31'd0, rsp_valid}, 32'd1);
            check({VTAG[i], " kind"}, {30'd0, rsp_kind}, {30'd0, VECS[i].kind});
            check({"R6 ", VTAG[i]}, {31'd0, rsp_trap64}, {31'd0, VECS[i].t64});
            check({"R4 code ", VTAG[i]}, {26'd0, rsp_code},
                  (VECS[i].kind == 2'd3) ? 32'h3 : 32'h0);
            if (VECS[i].kind == 2'd0)
                check({VTAG[i], " data"}, rsp_rdata, VECS[i].data);
        end
        req_valid = 0;
        step();
        check("R2 release", {31'd0, rsp_valid}, 32'd0);

        // R1: each field off by one value, written at EL3 NS
        for (int f = 0; f < 5; f++) begin
            set_req(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD_0000 + f);
            req_cp = (f == 0) ? 4'd14 : 4'd15;
            req_op1 = (f == 1) ? 3'd1 : 3'd0;
            req_crn = (f == 2) ? 4'd7 : 4'd6;
            req_crm = (f == 3) ? 4'd1 : 4'd0;
            req_op2 = (f == 4) ? 3'd3 : 3'd2;
            step();
            check("R1 miss silent", {31'd0, rsp_valid}, 32'd0);
        end
        req_valid = 0;
        req_cp = 4'd15; req_op1 = 3'd0; req_crn = 4'd6; req_crm = 4'd0; req_op2 = 3'd2;
        read_back(2'd3, 1'b1, "R1 contents kept", 32'h9999_0099);

        // R10: capture in Secure state, then in Non-secure state at EL1
        cur_el = 2'd3; sec_ns = 1'b0; abort_valid = 1; abort_va = 32'h1000_0040;
        step();
        abort_valid = 0;
        read_back(2'd3, 1'b0, "R10 secure capture", 32'h1000_0040);
        read_back(2'd3, 1'b1, "R10 ns untouched", 32'h9999_0099);
        cur_el = 2'd1; sec_ns = 1'b0; abort_valid = 1; abort_va = 32'h2000_0080;
        step();
        abort_valid = 0;
        read_back(2'd3, 1'b1, "R10 ns capture", 32'h2000_0080);
        read_back(2'd3, 1'b0, "R10 secure untouched", 32'h1000_0040);

        // R11: capture and write to the Secure entry in one cycle
        set_req(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h5555_5555);
        abort_valid = 1; abort_va = 32'h7777_7777;
        step();
        req_valid = 0; abort_valid = 0;
        check("R11 write ok", {30'd0, rsp_kind}, 32'd1);
        read_back(2'd3, 1'b0, "R11 capture wins", 32'h7777_7777);

        // R12: absent instance refuses a legal EL3 read
        set_req(2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        step();
        req_valid = 0;
        check("R12 valid", {31'd0, a_valid}, 32'd1);
        check("R12 undef", {30'd0, a_kind}, 32'd2);
        check("R12 present reads", {30'd0, rsp_kind}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule